// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous memory. It is 8 bits wide by default, and its depth is set by an address-width parameter. Every command has the same shape. On a rising edge the block captures an address, a chip select and a write-enable level. The data for that command moves in the next cycle, whether it is a read or a write. Because both directions share the same one-cycle lag, a read can follow a write, or a write can follow a read, on consecutive edges with no idle cycle between them.

Read data is flow-through. The word is presented combinationally from the array during the data cycle, with no extra output register behind it. A low-active clock enable suspends the whole block: new commands, the data phase already in flight and the outputs are all frozen. A low-active chip select controls whether a new command starts; it does not cancel a transfer that is already pending. The bidirectional data bus is split into three ports: a write-data input, a read-data output and an output-enable. An asynchronous output gate can force the output-enable off at any time.

The default address width is 10. Setting `ADDR_W` to 17 gives the full 128K-word organisation.

Top module: `zbt_sram_core`

## Requirements
- R1: On a rising edge with `clk_en_n`=0 and `sel_n`=0, the block captures `addr` and `wr_n` as a new command. `wr_n`=0 makes the command a write and `wr_n`=1 makes it a read.
- R2: For a write command, `wdata` is sampled at the rising edge that ends the cycle after the command's address edge, and it is stored at the captured address.
- R3: For a read command, during the cycle after its address edge, `rdata` equals the stored word at the captured address. If a write to that address completed at the same edge, `rdata` shows the newly written word.
- R4: On an edge with `clk_en_n`=1, every other synchronous input is ignored. A pending transfer stays pending, `rdata` and `rdata_oe` keep their values, and a pending write takes its `wdata` at the first edge where `clk_en_n` is low again.
- R5: `sel_n` and `wr_n` have no effect on an edge where `clk_en_n`=1.
- R6: On an edge with `clk_en_n`=0 and `sel_n`=1, no command starts and `wr_n` is ignored. A transfer pending from the previous command still completes, and `rdata_oe` is 0 in the following cycle.
- R7: Read and write commands on consecutive edges, in any order, all complete at full rate with no idle cycle inserted.
- R8: While `oe_n`=1, `rdata_oe` is 0 immediately and without waiting for a clock edge, whatever the pipeline state.
- R9: `rdata_oe` is 1 only during the data cycle of a read with `oe_n`=0. It is 0 during write data cycles and deselected cycles.
- R10: While `rst_n`=0, no transfer is pending and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the command stage |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Low selects write, high selects read |
| addr | input | ADDR_W | Command address |
| wdata | input | DATA_W | Write data for the write in its data cycle |
| oe_n | input | 1 | Asynchronous active-low output gate |
| rdata | output | DATA_W | Flow-through read data |
| rdata_oe | output | 1 | High when `rdata` should drive the shared bus |

## Verification
On every cycle, the embedded properties check three things. First, a captured command appears in the data stage one edge later with the right address and direction. Second, a stalled edge leaves the data stage and the output-enable unchanged. Third, deselect and write commands leave the output-enable low in the next cycle, and `oe_n` high forces it low at once.

Some behaviour only the bench scenarios can show, by comparing against a reference array. That covers the stored and returned data values, a write that commits after a long stall with data presented at the resume edge, and read-after-write forwarding on back-to-back commands. It also covers a full sweep of every address of a 16-word configuration.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zbt_op_e;

  function automatic zbt_op_e decode_op(input logic sel_n, input logic wr_n);
    if (sel_n) return OP_IDLE;
    return wr_n ? OP_READ : OP_WRITE;
  endfunction
endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output zbt_op_e           op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              advance
);
  zbt_op_e op_next;

  assign advance = ~clk_en_n;

  always_comb begin
    op_next = decode_op(sel_n, wr_n);
  end

  // Data-phase register: holds the command whose data moves this cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
    end else if (advance) begin
      op_q <= op_next;
      if (!sel_n) addr_q <= addr;
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sel_n) |=> (addr_q == $past(addr)) &&
                              ((op_q == OP_WRITE) == !$past(wr_n)) &&
                              (op_q != OP_IDLE));

  p_stall_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(op_q) && $stable(addr_q));

  p_desel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel_n) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Flow-through read: no output register.
  assign rdata = store[raddr];
endmodule

// File: rtl/zbt_out_gate.sv
module zbt_out_gate
  import zbt_pkg::*;
(
  input  zbt_op_e op_q,
  input  logic    oe_n,
  output logic    drive
);
  always_comb begin
    drive = (op_q == OP_READ) && !oe_n;
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  zbt_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              advance;
  logic              commit_wr;

  zbt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .op_q     (op_q),
    .addr_q   (addr_q),
    .advance  (advance)
  );

  // A pending write commits only on an edge that is not stalled.
  assign commit_wr = advance && (op_q == OP_WRITE);

  zbt_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (commit_wr),
    .waddr (addr_q),
    .wdata (wdata),
    .raddr (addr_q),
    .rdata (rdata)
  );

  zbt_out_gate u_gate (
    .op_q  (op_q),
    .oe_n  (oe_n),
    .drive (rdata_oe)
  );

  always_comb begin
    if (oe_n == 1'b1) begin
      p_oe_gate_r8: assert (rdata_oe == 1'b0);
    end
  end

  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      p_reset_quiet_r10: assert (rdata_oe == 1'b0);
    end
  end

  p_desel_tristate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sel_n) |=> !rdata_oe);

  p_write_phase_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sel_n && !wr_n) |=> !rdata_oe);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !oe_n) |=> (oe_n || ($past(rdata_oe) == rdata_oe)));
endmodule

// File: tb/zbt_sram_core_test.sv
module zbt_sram_core_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0, errors = 0;
  string tag = "R10";
  bit done = 0;

  // reference model
  logic m_valid = 0, m_write = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] ref_mem [DEPTH];
  bit known [DEPTH];
  bit last_stall = 0;

  always #5 clk = ~clk;

  zbt_sram_core #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(cen_n), .sel_n(cs_n), .wr_n(we_n),
    .addr(a), .wdata(d), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0;
      last_stall = 0;
    end else if (!cen_n) begin
      if (m_valid && m_write) begin
        ref_mem[m_addr] = d;
        known[m_addr] = 1;
      end
      m_valid = !cs_n;
      m_write = !we_n;
      if (!cs_n) m_addr = a;
      last_stall = 0;
    end else begin
      last_stall = 1;
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic exp_oe;
    string t;
    t = last_stall ? "R4" : tag;
    exp_oe = m_valid && !m_write && !oe_n;
    chk({t, " rdata_oe"}, {31'd0, rdata_oe}, {31'd0, exp_oe});
    if (exp_oe && known[m_addr]) chk({t, " rdata"}, {24'd0, rdata}, {24'd0, ref_mem[m_addr]});
  endtask

  // check current data phase, then drive the next edge's inputs
  task automatic step(input logic c, input logic s, input logic w,
                      input logic [AW-1:0] ad, input logic [DW-1:0] dt);
    @(negedge clk);
    compare();
    cen_n = c; cs_n = s; we_n = w; a = ad; d = dt;
  endtask

  function automatic logic [DW-1:0] pat(input int x, input int k);
    return DW'((x * 37 + k * 11 + 5) & 8'hff);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 reset oe", {31'd0, rdata_oe}, 32'd0);
    end
    rst_n = 1'b1;

    // R2 R7: write every address back to back, data sampled one cycle later
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, AW'(i), pat(i - 1, 0));
    step(0, 1, 1, '0, pat(DEPTH - 1, 0));
    // R3: read every address back to back
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, AW'(i), 8'h00);
    step(0, 1, 1, '0, 8'h00);
    // R7: alternating write then read of the same address, forwarding
    tag = "R7";
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, AW'(i), 8'h00);
      step(0, 0, 1, AW'(i), pat(i, 3));
    end
    step(0, 1, 1, '0, 8'h00);
    step(0, 1, 1, '0, 8'h00);

    // R6: deselect after a write still commits it; deselect after read drops oe
    tag = "R6";
    step(0, 0, 0, 4'd5, 8'h00);
    step(0, 1, 0, 4'd9, 8'hA5);     // deselect, wr_n low ignored
    step(0, 0, 1, 4'd5, 8'h00);
    step(0, 1, 0, 4'd9, 8'h3C);     // data phase of read shows A5; deselect next
    step(0, 0, 1, 4'd9, 8'h00);     // after deselect: oe low; addr 9 unchanged
    step(0, 1, 1, '0, 8'h00);

    // R4 R5: stall with a pending read, junk on sel/wr/addr
    tag = "R5";
    step(0, 0, 1, 4'd5, 8'h00);
    step(1, 0, 0, 4'd2, 8'hEE);
    step(1, 1, 0, 4'd3, 8'hEF);
    step(1, 0, 0, 4'd4, 8'hF0);
    step(0, 1, 1, '0, 8'h00);
    // R4: pending write frozen, takes wdata at resume edge
    tag = "R4";
    step(0, 0, 0, 4'd7, 8'h00);
    step(1, 0, 1, 4'd1, 8'h11);
    step(1, 1, 0, 4'd2, 8'h22);
    step(0, 0, 1, 4'd7, 8'h6D);     // resume: 6D written, read 7 issued
    step(0, 1, 1, '0, 8'h00);
    step(0, 1, 1, '0, 8'h00);

    // R8: oe_n raised mid data cycle forces oe low without an edge
    tag = "R8";
    step(0, 0, 1, 4'd7, 8'h00);
    step(0, 1, 1, '0, 8'h00);
    #1 oe_n = 1'b1;
    #1 chk("R8 async gate", {31'd0, rdata_oe}, 32'd0);
    #1 oe_n = 1'b0;
    #1 chk("R8 gate release", {31'd0, rdata_oe}, 32'd1);

    // R9 R1: random mix against the reference model
    tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      @(negedge clk);
      compare();
      oe_n = ($urandom_range(0, 7) == 0);
      cen_n = (r == 0);
      cs_n = (r == 1);
      we_n = $urandom_range(0, 1);
      a = AW'($urandom_range(0, DEPTH - 1));
      d = DW'($urandom_range(0, 255));
      tag = (n % 2 == 0) ? "R1" : "R9";
    end
    step(0, 1, 1, '0, 8'h00);
    @(negedge clk);
    compare();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule